// File: doc/BRIEF.md
# Decimating Low-Pass FIR (Single Shared MAC)

This block turns a stream of signed 24-bit converter samples at 768 kHz into a stream at 96 kHz. It applies a long, linear-phase low-pass FIR whose passband ends well below the 48 kHz limit of the output rate, so that content which would fold back is removed before the rate drops. Only the outputs that are kept are ever computed: one output for every eighth input sample. The other seven samples are only written into the sample history.

One multiply-accumulate unit runs on a fast system clock and is shared across all taps. Samples sit in a circular single-write, single-read RAM. The coefficients are a symmetric integer kernel that the design builds at elaboration. The wide sum is rounded to nearest and clamped back to 24 bits before it leaves the block. The tap count, the decimation factor, the coefficient scale and the output shift are all parameters. The defaults give 1025 taps (order 1024) and a factor of 8.

Top module: `fir_decim`

## Requirements
- R1: Tap k (0 to TAPS-1) has the coefficient COEF_SCALE*(k+1)*(TAPS-k). Each result is the sum over k of coef[k]*x[n-k], where x[n] is the sample whose arrival triggers the result. The oldest sample therefore meets the last coefficient.
- R2: Accepted inputs are counted from reset. A computation starts only on the DECIM-th, 2*DECIM-th, ... input. Each computation gives exactly one single-cycle `out_valid` pulse. Other inputs produce no output.
- R3: After reset the history reads as zero. Until TAPS samples have arrived, a result includes only the samples received so far.
- R4: The wide sum is scaled by 2^-SHIFT and rounded half-up, that is floor((sum + 2^(SHIFT-1)) / 2^SHIFT).
- R5: A scaled result above 2^23-1 gives 2^23-1, and one below -2^23 gives -2^23. The sum never wraps, even with every sample at full scale.
- R6: If a computation is due while the previous one is still in flight, `overrun` goes high and stays high until reset. The request is dropped and produces no output.
- R7: `out_valid` rises TAPS+2 clock edges after the edge that takes the triggering sample. Samples accepted while a computation runs do not change its result. Starts may be spaced down to TAPS+3 clocks.
- R8: While reset is active and right after it, `out_valid`, `out_data` and `overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe, at most one per clock |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a decimated result |
| out_data | output | 24 | Signed, rounded and saturated result |
| overrun | output | 1 | Sticky flag: a computation was requested while busy |

## Verification
The bench builds the block with 16 taps, a factor of 4 and a shift of 8, so the kernel gain is 816/256. A full-scale constant therefore drives the result into both clamps. An impulse of +/-64 landing on the coefficients 30, 42, 66 and 70 gives exact half-way sums, so the direction of rounding shows at the port. The short history also lets an impulse walk through every tap and out again within a few outputs, and lets the zero-fill start-up be seen across the first four results. Samples spaced six clocks apart land in the middle of each computation, while back-to-back samples force the overrun path.

// File: rtl/fir_decim_pkg.sv
package fir_decim_pkg;

   // Symmetric parabolic low-pass kernel, computed at elaboration
   function automatic longint tap_coef(input int k, input int taps, input int scale);
      return longint'(scale) * longint'(k + 1) * longint'(taps - k);
   endfunction

endpackage

// File: rtl/fir_hist_ram.sv
module fir_hist_ram #(
   parameter int DATA_W = 24,
   parameter int DEPTH  = 1025,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   // read returns the old word on a same-address write
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq #(
   parameter int DATA_W     = 24,
   parameter int COEF_W     = 24,
   parameter int TAPS       = 1025,
   parameter int DECIM      = 8,
   parameter int COEF_SCALE = 1,
   parameter int AW         = $clog2(TAPS),
   parameter int ACC_W      = DATA_W + COEF_W + $clog2(TAPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [DATA_W-1:0]       in_data,
   output logic                    ram_we,
   output logic [AW-1:0]           ram_waddr,
   output logic [DATA_W-1:0]       ram_wdata,
   output logic                    ram_re,
   output logic [AW-1:0]           ram_raddr,
   input  logic [DATA_W-1:0]       ram_rdata,
   output logic signed [ACC_W-1:0] acc_out,
   output logic                    acc_done,
   output logic                    overrun
);

   localparam int PW  = DATA_W + COEF_W;
   localparam int CW  = $clog2(TAPS + 1);
   localparam int PHW = (DECIM > 1) ? $clog2(DECIM) : 1;

   logic [PHW-1:0]          phase;
   logic [AW-1:0]           wp, wp_nx, rd_addr;
   logic [CW-1:0]           fill, fill_nx, cnt, zskip;
   logic                    active, pv, pmask, plast, fin, start, busy;
   logic signed [COEF_W-1:0] coef_r;
   logic signed [COEF_W-1:0] rom [TAPS];
   logic [AW-1:0]           cidx;
   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] acc;

   function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
      return (a == AW'(TAPS - 1)) ? '0 : a + 1'b1;
   endfunction

   // coefficient table, one entry per tap
   for (genvar k = 0; k < TAPS; k++) begin : g_rom
      assign rom[k] = COEF_W'(fir_decim_pkg::tap_coef(k, TAPS, COEF_SCALE));
   end

   assign wp_nx   = wrap_inc(wp);
   assign fill_nx = (fill == CW'(TAPS)) ? fill : fill + 1'b1;
   assign start   = in_valid && (phase == PHW'(DECIM - 1));
   assign busy    = active | pv | fin;
   assign cidx    = AW'(TAPS - 1 - int'(cnt));
   assign prod    = $signed(ram_rdata) * coef_r;

   assign ram_we    = in_valid;
   assign ram_waddr = wp;
   assign ram_wdata = in_data;
   assign ram_re    = active;
   assign ram_raddr = rd_addr;
   assign acc_out   = acc;
   assign acc_done  = fin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= '0;
         wp      <= '0;
         fill    <= '0;
         active  <= 1'b0;
         cnt     <= '0;
         rd_addr <= '0;
         zskip   <= '0;
         pv      <= 1'b0;
         pmask   <= 1'b0;
         plast   <= 1'b0;
         coef_r  <= '0;
         fin     <= 1'b0;
         acc     <= '0;
         overrun <= 1'b0;
      end else begin
         if (in_valid) begin
            wp    <= wp_nx;
            fill  <= fill_nx;
            phase <= (phase == PHW'(DECIM - 1)) ? '0 : phase + 1'b1;
         end
         if (start) begin
            if (busy) begin
               overrun <= 1'b1;
            end else begin
               // sweep starts at the oldest slot, just past the newest
               active  <= 1'b1;
               cnt     <= '0;
               rd_addr <= wp_nx;
               zskip   <= CW'(TAPS) - fill_nx;
               acc     <= '0;
            end
         end
         if (active) begin
            pv      <= 1'b1;
            pmask   <= (cnt < zskip);
            plast   <= (cnt == CW'(TAPS - 1));
            coef_r  <= rom[cidx];
            rd_addr <= wrap_inc(rd_addr);
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(TAPS - 1)) active <= 1'b0;
         end else begin
            pv    <= 1'b0;
            plast <= 1'b0;
         end
         if (pv && !pmask) acc <= acc + {{(ACC_W - PW){prod[PW-1]}}, prod};
         fin <= pv && plast;
      end
   end

   p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(TAPS));
   p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (active && !fin));
   p_wp_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wp <= AW'(TAPS - 1)) && (rd_addr <= AW'(TAPS - 1)));

endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
   parameter int ACC_W = 59,
   parameter int OUT_W = 24,
   parameter int SHIFT = 28
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [OUT_W-1:0] y
);

   localparam int SW = ACC_W + 1;
   localparam logic signed [SW-1:0] ONE  = 1;
   localparam logic signed [SW-1:0] MAXV = (ONE <<< (OUT_W - 1)) - ONE;
   localparam logic signed [SW-1:0] MINV = -(ONE <<< (OUT_W - 1));

   logic signed [SW-1:0] biased, scaled;

   if (SHIFT == 0) begin : g_noround
      assign biased = {acc[ACC_W-1], acc};
   end else begin : g_round
      assign biased = {acc[ACC_W-1], acc} + (ONE <<< (SHIFT - 1));
   end

   assign scaled = biased >>> SHIFT;

   always_comb begin
      if (scaled > MAXV)      y = MAXV[OUT_W-1:0];
      else if (scaled < MINV) y = MINV[OUT_W-1:0];
      else                    y = scaled[OUT_W-1:0];
   end

endmodule

// File: rtl/fir_decim.sv
module fir_decim #(
   parameter int DATA_W     = 24,
   parameter int COEF_W     = 24,
   parameter int TAPS       = 1025,
   parameter int DECIM      = 8,
   parameter int COEF_SCALE = 1,
   parameter int SHIFT      = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              overrun
);

   localparam int AW    = $clog2(TAPS);
   localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS);
   localparam longint CMAX  = fir_decim_pkg::tap_coef(TAPS / 2, TAPS, COEF_SCALE);
   localparam longint CLIM  = (longint'(1) << (COEF_W - 1)) - 1;

   if (TAPS < 2) begin : g_bad_taps
      $error("fir_decim: TAPS must be at least 2");
   end
   if (DECIM < 1) begin : g_bad_decim
      $error("fir_decim: DECIM must be at least 1");
   end
   if (CMAX > CLIM || COEF_SCALE < 1) begin : g_bad_coef
      $error("fir_decim: coefficients do not fit COEF_W");
   end
   if (SHIFT < 0 || SHIFT >= ACC_W) begin : g_bad_shift
      $error("fir_decim: SHIFT out of range");
   end

   logic                    ram_we, ram_re;
   logic [AW-1:0]           ram_waddr, ram_raddr;
   logic [DATA_W-1:0]       ram_wdata, ram_rdata;
   logic signed [ACC_W-1:0] acc;
   logic                    acc_done;
   logic signed [DATA_W-1:0] res;

   fir_hist_ram #(.DATA_W(DATA_W), .DEPTH(TAPS), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .re    (ram_re),
      .raddr (ram_raddr),
      .rdata (ram_rdata)
   );

   fir_mac_seq #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .DECIM(DECIM),
      .COEF_SCALE(COEF_SCALE), .AW(AW), .ACC_W(ACC_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .ram_we    (ram_we),
      .ram_waddr (ram_waddr),
      .ram_wdata (ram_wdata),
      .ram_re    (ram_re),
      .ram_raddr (ram_raddr),
      .ram_rdata (ram_rdata),
      .acc_out   (acc),
      .acc_done  (acc_done),
      .overrun   (overrun)
   );

   fir_round_sat #(.ACC_W(ACC_W), .OUT_W(DATA_W), .SHIFT(SHIFT)) u_rs (
      .acc (acc),
      .y   (res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= acc_done;
         if (acc_done) out_data <= res;
      end
   end

   p_out_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

// File: tb/test_fir_decim.sv
module test_fir_decim;

   localparam int T  = 16;
   localparam int D  = 4;
   localparam int SH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_data = '0;
   logic        out_valid;
   logic [23:0] out_data;
   logic        overrun;

   always #2.5 clk = ~clk;

   fir_decim #(.DATA_W(24), .COEF_W(24), .TAPS(T), .DECIM(D),
               .COEF_SCALE(1), .SHIFT(SH)) i_fir_decim (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
   );

   int     checks = 0;
   int     fails  = 0;
   longint cyc    = 0;
   int     nin    = 0;
   int     out_cnt = 0;
   int     gap    = 6;
   bit     expect_on = 1'b1;
   bit     done = 1'b0;
   string  cur_tag = "";
   int     xs[$];
   longint exp_val[$];
   longint exp_cyc[$];
   string  exp_tag[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic longint hcoef(input int k);
      return longint'(k + 1) * longint'(T - k);
   endfunction

   function automatic longint ref_out();
      longint acc = 0;
      longint y;
      for (int j = 0; j < T; j++)
         if (nin - 1 - j >= 0) acc += hcoef(j) * longint'(xs[nin - 1 - j]);
      y = (acc + (longint'(1) <<< (SH - 1))) >>> SH;
      if (y > 8388607)  y = 8388607;
      if (y < -8388608) y = -8388608;
      return y;
   endfunction

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         out_cnt++;
         if (expect_on) begin
            if (exp_val.size() == 0) begin
               chk(1'b0, "R2 output with no computation due", 1, 0);
            end else begin
               longint ev, ec;
               string  et;
               ev = exp_val.pop_front();
               ec = exp_cyc.pop_front();
               et = exp_tag.pop_front();
               chk(longint'($signed(out_data)) == ev, et, longint'($signed(out_data)), ev);
               chk(cyc == ec, "R7 result latency", cyc, ec);
            end
         end
      end
   end

   task automatic send(input int v);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = v[23:0];
      xs.push_back(v);
      nin++;
      if (expect_on && (nin % D == 0)) begin
         exp_val.push_back(ref_out());
         exp_cyc.push_back(cyc + T + 3);
         exp_tag.push_back(cur_tag);
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      xs.delete(); exp_val.delete(); exp_cyc.delete(); exp_tag.delete();
      nin = 0; out_cnt = 0; gap = 6; expect_on = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic drain(input string tag);
      repeat (T + 8) @(negedge clk);
      chk(exp_val.size() == 0, {tag, " R2 all results delivered"}, exp_val.size(), 0);
      chk(out_cnt == nin / D, {tag, " R2 one result per DECIM inputs"}, out_cnt, nin / D);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
      chk(overrun == 1'b0, "R8 overrun in reset", overrun, 0);
      do_reset();
      chk(out_data == 24'd0, "R8 out_data after reset", out_data, 0);
      chk(overrun == 1'b0, "R8 overrun after reset", overrun, 0);
   endtask

   // impulse walks through every tap and out (R1, R3)
   task automatic t_impulse();
      do_reset();
      cur_tag = "R1 impulse response";
      send(256);
      for (int i = 0; i < 23; i++) send(0);
      drain("impulse");
   endtask

   // constant after reset: start-up sums only the received samples (R3)
   task automatic t_fill();
      do_reset();
      cur_tag = "R3 zero history at start";
      for (int i = 0; i < 24; i++) send(1000);
      drain("fill");
   endtask

   // +/-64 on coefficients 42,70,66,30 gives exact halves (R4)
   task automatic t_round();
      do_reset();
      cur_tag = "R4 round half up positive";
      send(0);
      send(64);
      for (int i = 0; i < 18; i++) send(0);
      drain("round+");
      do_reset();
      cur_tag = "R4 round half up negative";
      send(0);
      send(-64);
      for (int i = 0; i < 18; i++) send(0);
      drain("round-");
   endtask

   task automatic t_saturate();
      do_reset();
      cur_tag = "R5 clamp high";
      for (int i = 0; i < 24; i++) send(8388607);
      cur_tag = "R5 clamp low, no wrap";
      for (int i = 0; i < 24; i++) send(-8388608);
      drain("saturate");
   endtask

   // varied full-range data, samples land mid-computation (R1, R7)
   task automatic t_mixed();
      logic [31:0] s = 32'h1234_5678;
      do_reset();
      cur_tag = "R1 mixed data";
      for (int i = 0; i < 40; i++) begin
         int v;
         s = s * 32'd1103515245 + 32'd12345;
         v = int'({{8{s[31]}}, s[31:8]});
         send(v);
      end
      drain("mixed");
   endtask

   task automatic t_overrun();
      do_reset();
      expect_on = 1'b0;
      gap = 1;
      for (int i = 0; i < 8; i++) send(500);
      repeat (T + 8) @(negedge clk);
      chk(overrun == 1'b1, "R6 overrun raised", overrun, 1);
      chk(out_cnt == 1, "R6 dropped request gives no result", out_cnt, 1);
      repeat (20) @(negedge clk);
      chk(overrun == 1'b1, "R6 overrun sticky", overrun, 1);
      do_reset();
      chk(overrun == 1'b0, "R8 overrun cleared by reset", overrun, 0);
   endtask

   initial begin
      t_reset_state();
      t_impulse();
      t_fill();
      t_round();
      t_saturate();
      t_mixed();
      t_overrun();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule